// File: doc/BRIEF.md
# MDIO Management Serial Slave

This block is the PHY-side end of the two-wire station management link defined in IEEE 802.3 Clause 22. It runs on the management clock and samples the data line on each rising edge. After one or more idle ones it looks for the frame start, the operation code, the 5-bit PHY address and the 5-bit register address. On a read, it takes over the data line and shifts a 16-bit word back to the station. On a write, it collects 16 data bits and stores them in a small local register bank.

The block does not drive a pad itself. It provides a data bit and an enable, and an external tri-state buffer uses them. Its own PHY address comes from strap inputs. A PHY address of zero is treated as a broadcast, so the block answers it whatever the strap value is. The local bank implements registers `0..NUM_REGS-1`. After reset, register `i` holds `RST_BASE + i` (default `16'hA500 + i`).

Top module: `mdio_slave`

## Requirements
- R1: After reset the output enable is low, and register `i` of the bank (`i < NUM_REGS`, default 8) reads back as `16'hA500 + i`.
- R2: A single idle one before the start pattern is enough to accept a frame. A run of 32 ones is accepted too.
- R3: The start pattern is `0` then `1`. The read opcode is `1,0` and the write opcode is `0,1`. Any other start or opcode abandons the frame: the output is never enabled and no register changes.
- R4: In a read frame the line stays released during the first turnaround bit. During the second turnaround bit the enable is high and the data bit is 0.
- R5: Read data follows the turnaround most significant bit first, 16 bits with the enable high. The enable drops in the bit period after the last data bit.
- R6: A read whose PHY address matches neither the strap nor zero returns `16'hFFFF`. A read of a register address at or above `NUM_REGS` also returns `16'hFFFF`.
- R7: A write stores the 16 received data bits (MSB first) into the addressed register once the sixteenth bit is sampled. A write to a non-matching PHY address, or to an unimplemented register, changes no register.
- R8: Reads and writes with PHY address zero are served as if the address matched the strap.
- R9: The output enable stays low for the whole of a write frame, including the turnaround bits, which are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled value of the management data line |
| phy_addr_i | input | 5 | Strapped PHY address of this slave |
| mdio_o | output | 1 | Data bit driven during read turnaround and data |
| mdio_oe_o | output | 1 | Enable for the external tri-state driver |

## Verification
The hardest case to reach from the ports is an abandoned frame that must leave no trace. Bits that arrive after a bad start or opcode could themselves form a new valid header, and the test would then be measuring something else. The bench sends each bad header with every later bit at zero except the turnaround pair. Those zeros hold the hunter idle, and the test then reads the register that the aborted write aimed at. The strap is also moved during the run, which shows that matching follows the live pins and that broadcast still hits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    S_HUNT,
    S_PRE,
    S_SOF,
    S_OP,
    S_ADDR,
    S_TA,
    S_DATA
  } state_e;
endpackage

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RST_BASE = 16'hA500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              impl_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[i] <= RST_BASE + DATA_W'(i);
      else if (we_i && addr_i == ADDR_W'(i))        regs_q[i] <= wdata_i;
    end
  end

  assign impl_o = 32'(addr_i) < NUM_REGS;

  always_comb begin
    rdata_o = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  // R7: the controller only commits writes aimed at implemented registers
  assert_write_implemented_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(addr_i) < NUM_REGS));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_impl_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(2*ADDR_W-1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W-1);

  state_e              state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   sh_q;
  logic [ADDR_W-1:0]   phy_q, reg_q;
  logic                rd_q, oe_q, dout_q;
  logic                hit;
  logic [1:0]          op_now;

  assign op_now     = {sh_q[0], mdio_i};
  assign hit        = (phy_q == phy_addr_i) || (phy_q == '0);
  assign reg_addr_o = reg_q;
  assign wdata_o    = {sh_q[DATA_W-2:0], mdio_i};
  assign we_o       = (state_q == S_DATA) && !rd_q && (cnt_q == DATA_LAST) && hit && rd_impl_i;
  assign mdio_o     = dout_q;
  assign mdio_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      unique case (state_q)
        S_HUNT: if (mdio_i) state_q <= S_PRE;
        S_PRE:  if (!mdio_i) state_q <= S_SOF;
        S_SOF: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? S_OP : S_HUNT;
        end
        S_OP: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == OP_LAST) begin
            cnt_q <= '0;
            if (op_now == OP_RD || op_now == OP_WR) begin
              state_q <= S_ADDR;
              rd_q    <= (op_now == OP_RD);
            end else begin
              state_q <= S_HUNT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_ADDR: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == ADDR_LAST) begin
            phy_q   <= sh_q[2*ADDR_W-2:ADDR_W-1];
            reg_q   <= {sh_q[ADDR_W-2:0], mdio_i};
            cnt_q   <= '0;
            state_q <= S_TA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_TA: begin
          if (cnt_q == '0) begin
            cnt_q <= CNT_W'(1);
            if (rd_q) begin
              oe_q   <= 1'b1;
              dout_q <= 1'b0;
              sh_q   <= (hit && rd_impl_i) ? rd_data_i : '1;
            end
          end else begin
            cnt_q   <= '0;
            state_q <= S_DATA;
            if (rd_q) begin
              dout_q <= sh_q[DATA_W-1];
              sh_q   <= {sh_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        S_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (rd_q) begin
            if (cnt_q == DATA_LAST) begin
              oe_q    <= 1'b0;
              dout_q  <= 1'b1;
              state_q <= S_HUNT;
            end else begin
              dout_q <= sh_q[DATA_W-1];
              sh_q   <= {sh_q[DATA_W-2:0], 1'b1};
            end
          end else begin
            sh_q <= {sh_q[DATA_W-2:0], mdio_i};
            if (cnt_q == DATA_LAST) state_q <= S_HUNT;
          end
        end
        default: state_q <= S_HUNT;
      endcase
    end
  end

  // R4: the driver comes on only in turnaround, driving zero first
  assert_ta_drive_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> (!mdio_o && state_q == S_TA));

  // R9: never drive during a write frame
  assert_no_drive_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> rd_q);

  // R5: release happens only as the data phase ends
  assert_release_after_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> ($past(state_q) == S_DATA && state_q == S_HUNT));
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RST_BASE = 16'hA500
) (
  input  logic              mdc_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic [ADDR_W-1:0] reg_addr;
  logic              we, impl;
  logic [DATA_W-1:0] wdata, rdata;

  mdio_frame_ctrl u_ctrl (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .phy_addr_i (phy_addr_i),
    .rd_data_i  (rdata),
    .rd_impl_i  (impl),
    .reg_addr_o (reg_addr),
    .we_o       (we),
    .wdata_o    (wdata),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  mdio_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .RST_BASE (RST_BASE)
  ) u_bank (
    .clk_i   (mdc_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (reg_addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .impl_o  (impl)
  );
endmodule

// File: tb/mdio_slave_test.sv
module mdio_slave_test;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdio_i = 1'b1;
  logic [4:0] phy = 5'd5;
  logic       mdio_o, mdio_oe_o;
  int         n_chk = 0, n_fail = 0;
  logic [15:0] shadow [8];

  mdio_slave uut (
    .mdc_i(mdc), .rst_ni(rst_n), .mdio_i(mdio_i), .phy_addr_i(phy),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  always #2 mdc = ~mdc;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] sof, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) drive_bit(1'b1);
    drive_bit(sof[1]); drive_bit(sof[0]);
    drive_bit(op[1]);  drive_bit(op[0]);
    for (int i = 4; i >= 0; i--) drive_bit(pa[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
  endtask

  task automatic do_read(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] exp, input string req);
    logic [15:0] got = '0;
    bit ta_ok = 1, oe_ok = 1;
    send_hdr(pre, 2'b01, 2'b10, pa, ra);
    for (int k = 0; k < 18; k++) begin
      @(negedge mdc);
      mdio_i = 1'b1;
      if (k == 0) ta_ok &= (mdio_oe_o == 1'b0);
      else if (k == 1) ta_ok &= (mdio_oe_o == 1'b1 && mdio_o == 1'b0);
      else begin
        got = {got[14:0], mdio_o};
        oe_ok &= mdio_oe_o;
      end
    end
    check(ta_ok, "R4 turnaround", {31'd0, ta_ok}, 32'd1);
    check(got == exp && oe_ok, req, {15'd0, oe_ok, got}, {16'd1, exp});
    @(negedge mdc);
    check(mdio_oe_o == 1'b0, "R5 release", {31'd0, mdio_oe_o}, 32'd0);
  endtask

  task automatic do_write(input int pre, input logic [1:0] sof, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    bit quiet = 1;
    send_hdr(pre, sof, op, pa, ra);
    drive_bit(1'b1); quiet &= !mdio_oe_o;
    drive_bit(1'b0); quiet &= !mdio_oe_o;
    for (int i = 15; i >= 0; i--) begin drive_bit(d[i]); quiet &= !mdio_oe_o; end
    drive_bit(1'b1); quiet &= !mdio_oe_o;
    check(quiet, "R9/R3 no drive", {31'd0, quiet}, 32'd1);
  endtask

  function automatic logic [15:0] patt(input int r);
    return 16'((r * 16'h1357) ^ 16'hBEEF);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge mdc);
    check(mdio_oe_o == 1'b0, "R1 reset oe", {31'd0, mdio_oe_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge mdc);

    // R1/R6/R2: register sweep with one-bit preamble
    for (int r = 0; r < 32; r++)
      do_read(1, 5'd5, 5'(r), (r < 8) ? 16'hA500 + 16'(r) : 16'hFFFF, "R1/R6 reg sweep");

    // R8/R6/R2: PHY address sweep, 32-bit preamble on half
    for (int p = 0; p < 32; p++)
      do_read((p % 2) ? 32 : 1, 5'(p), 5'd3,
              (p == 5 || p == 0) ? 16'hA503 : 16'hFFFF, "R8/R6 phy sweep");

    // R7: write all implemented registers, then read back
    for (int r = 0; r < 8; r++) begin
      do_write(1, 2'b01, 2'b01, 5'd5, 5'(r), patt(r));
      shadow[r] = patt(r);
    end
    for (int r = 0; r < 8; r++) do_read(1, 5'd5, 5'(r), shadow[r], "R7 write readback");

    // R7: mismatched PHY and unimplemented register leave the bank alone
    do_write(2, 2'b01, 2'b01, 5'd9, 5'd2, 16'h0000);
    do_read(1, 5'd5, 5'd2, shadow[2], "R7 unmatched write");
    do_write(1, 2'b01, 2'b01, 5'd5, 5'd20, 16'h0000);
    do_read(1, 5'd5, 5'd4, shadow[4], "R7 unimpl write alias");
    do_read(1, 5'd5, 5'd20, 16'hFFFF, "R6 unimpl read");

    // R8: broadcast write
    do_write(32, 2'b01, 2'b01, 5'd0, 5'd1, 16'h1234);
    shadow[1] = 16'h1234;
    do_read(1, 5'd5, 5'd1, shadow[1], "R8 broadcast write");

    // R3: bad opcodes and bad start, all trailing bits zero
    do_write(4, 2'b01, 2'b11, 5'd0, 5'd0, 16'h0000);
    do_read(1, 5'd5, 5'd0, shadow[0], "R3 opcode 11");
    do_write(4, 2'b01, 2'b00, 5'd0, 5'd0, 16'h0000);
    do_read(1, 5'd5, 5'd0, shadow[0], "R3 opcode 00");
    do_write(4, 2'b00, 2'b01, 5'd0, 5'd0, 16'h0000);
    do_read(1, 5'd5, 5'd0, shadow[0], "R3 bad start");

    // R6/R8: strap change
    phy = 5'd17;
    do_read(1, 5'd17, 5'd5, shadow[5], "R6 new strap");
    do_read(1, 5'd5, 5'd5, 16'hFFFF, "R6 old strap");
    do_read(1, 5'd0, 5'd6, shadow[6], "R8 broadcast read");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule